// File: doc/BRIEF.md
# Banked Scratch RAM with Bit Access and Hardware Stack

This block is the on-chip data memory front end of a small 8-bit controller core. It holds 128 bytes of storage and offers several ways to reach them. A byte port takes either a direct 7-bit address, or a pointer read from working register 0 or 1 of the active bank. A register port names one of eight working registers, and the block maps that name into the bank chosen by two bank-select inputs. A bit port sets, clears or reads single bits inside a fixed 16-byte bit window. A hardware stack pointer supports push and pop.

All paths share one write port. Each access takes one cycle, and read results appear on registered outputs one cycle after the request. The surrounding core issues at most one request per cycle. If several arrive together, the block serves them in this order: push, pop, byte port, register port, bit port.

Top module: `banked_scratch_ram`

## Requirements
- R1: After reset the stack pointer is 07h, `rd_data` and `bit_q` are 0, and both stack flags are 0.
- R2: A register-port access to register n (0..7) while the bank inputs select bank b (0..3) reaches byte address 8*b+n. A read shows that byte on `rd_data` one cycle after the request.
- R3: A byte-port access with `byte_ind`=0 reaches the byte at `byte_addr` (00h..7Fh). A write stores `byte_wdata`, and a read shows the byte on `rd_data` one cycle later.
- R4: With `byte_ind`=1, the address is the low 7 bits of register 0 (`byte_ptr`=0) or register 1 (`byte_ptr`=1) of the current bank. Pointer bit 7 is ignored.
- R5: Bit address k (00h..7Fh) names bit position k mod 8 of byte 20h + k div 8. A bit write (`bit_we`=1) stores `bit_val` there in one cycle and leaves the other seven bits of that byte as they were. A bit read shows the bit on `bit_q` one cycle later.
- R6: A push with the stack pointer below 7Fh first increments the pointer and then writes `push_data` at the new value, so the first push after reset lands at 08h.
- R7: A pop with the stack pointer above 00h shows the byte at the current pointer on `rd_data` one cycle later and decrements the pointer.
- R8: A push with the stack pointer at 7Fh raises `ovf` for exactly one cycle and changes neither the pointer nor any byte.
- R9: A pop with the stack pointer at 00h raises `unf` for exactly one cycle and changes neither the pointer nor `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank | input | 2 | Selects the active register bank |
| byte_en | input | 1 | Byte-port request |
| byte_we | input | 1 | Byte-port write (1) or read (0) |
| byte_ind | input | 1 | Use a register as the pointer instead of `byte_addr` |
| byte_ptr | input | 1 | Pointer register: 0 selects register 0, 1 selects register 1 |
| byte_addr | input | 7 | Direct byte address |
| byte_wdata | input | 8 | Byte-port write data |
| reg_en | input | 1 | Register-port request |
| reg_we | input | 1 | Register-port write (1) or read (0) |
| reg_num | input | 3 | Working register number 0..7 |
| reg_wdata | input | 8 | Register-port write data |
| bit_en | input | 1 | Bit-port request |
| bit_we | input | 1 | Bit write (1) or bit read (0) |
| bit_addr | input | 7 | Bit address |
| bit_val | input | 1 | Value for a bit write |
| push | input | 1 | Push request |
| push_data | input | 8 | Byte to push |
| pop | input | 1 | Pop request |
| rd_data | output | 8 | Registered read data from byte, register and pop accesses |
| bit_q | output | 1 | Registered result of a bit read |
| sp | output | 7 | Current stack pointer |
| ovf | output | 1 | One-cycle pulse: push refused at the top |
| unf | output | 1 | One-cycle pulse: pop refused at the bottom |

## Verification
The assertions assume that a push or pop request is the only request in its cycle. Under that assumption, the stack pointer moves by exactly one or, at a boundary, holds still while the matching flag pulses. The stimulus never raises two requests in the same cycle. It walks the pointer from 07h to the top, tries one push past the top, then walks it down to 00h and tries one pop past the bottom, so that both boundaries are reached in order. Register and bit sweeps cover every bank, register number and bit address, and the indirect pointers are loaded with bit 7 set.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Byte address of working register num within bank.
  function automatic int unsigned reg_slot(int unsigned bank, int unsigned num,
                                           int unsigned per_bank);
    return bank * per_bank + num;
  endfunction

  // Byte that holds bit address k inside the bit window.
  function automatic int unsigned bit_home(int unsigned k, int unsigned base,
                                           int unsigned width);
    return base + k / width;
  endfunction

  // Bit position of bit address k inside its byte.
  function automatic int unsigned bit_lane(int unsigned k, int unsigned width);
    return k % width;
  endfunction

endpackage

// File: rtl/bsr_resolve.sv
module bsr_resolve #(
  parameter int AW            = 7,
  parameter int NB_W          = 2,
  parameter int RN_W          = 3,
  parameter int BIT_W         = 7,
  parameter int POS_W         = 3,
  parameter int REGS_PER_BANK = 8,
  parameter int BIT_BASE      = 32
) (
  input  logic [NB_W-1:0]  bank_i,
  input  logic [RN_W-1:0]  reg_num_i,
  input  logic             ptr_sel_i,
  input  logic [BIT_W-1:0] bit_addr_i,
  output logic [AW-1:0]    reg_addr_o,
  output logic [AW-1:0]    ptr_addr_o,
  output logic [AW-1:0]    bit_byte_o,
  output logic [POS_W-1:0] bit_pos_o
);
  localparam int LANES = 1 << POS_W;

  assign reg_addr_o = AW'(bsr_pkg::reg_slot(int'(bank_i), int'(reg_num_i), REGS_PER_BANK));
  assign ptr_addr_o = AW'(bsr_pkg::reg_slot(int'(bank_i), int'(ptr_sel_i), REGS_PER_BANK));
  assign bit_byte_o = AW'(bsr_pkg::bit_home(int'(bit_addr_i), BIT_BASE, LANES));
  assign bit_pos_o  = POS_W'(bsr_pkg::bit_lane(int'(bit_addr_i), LANES));
endmodule

// File: rtl/bsr_stack.sv
module bsr_stack #(
  parameter int AW      = 7,
  parameter int SP_INIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] push_slot_o,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam logic [AW-1:0] SP_TOP = '1;
  localparam logic [AW-1:0] SP_BOT = '0;

  logic [AW-1:0] sp_q;

  assign push_ok_o   = push_i && (sp_q != SP_TOP);
  assign pop_ok_o    = pop_i && (sp_q != SP_BOT);
  assign push_slot_o = sp_q + AW'(1);
  assign sp_o        = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= AW'(SP_INIT);
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= push_i && !push_ok_o;
      unf_o <= pop_i && !pop_ok_o;
      if (push_ok_o)     sp_q <= push_slot_o;
      else if (pop_ok_o) sp_q <= sp_q - AW'(1);
    end
  end

  assert_push_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && sp_q != SP_TOP) |=> (sp_q == $past(sp_q) + AW'(1)) && !ovf_o);
  assert_pop_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && sp_q != SP_BOT) |=> (sp_q == $past(sp_q) - AW'(1)) && !unf_o);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && sp_q == SP_TOP) |=> ovf_o && $stable(sp_q));
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && sp_q == SP_BOT) |=> unf_o && $stable(sp_q));
endmodule

// File: rtl/bsr_store.sv
module bsr_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_a_i,
  output logic [DW-1:0]            rdata_a_o,
  input  logic [$clog2(DEPTH)-1:0] raddr_b_i,
  output logic [DW-1:0]            rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/banked_scratch_ram.sv
module banked_scratch_ram #(
  parameter int DEPTH         = 128,
  parameter int DW            = 8,
  parameter int NUM_BANKS     = 4,
  parameter int REGS_PER_BANK = 8,
  parameter int BIT_BASE      = 32,
  parameter int BIT_BYTES     = 16,
  parameter int SP_INIT       = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [$clog2(NUM_BANKS)-1:0]     bank,
  input  logic                             byte_en,
  input  logic                             byte_we,
  input  logic                             byte_ind,
  input  logic                             byte_ptr,
  input  logic [$clog2(DEPTH)-1:0]         byte_addr,
  input  logic [DW-1:0]                    byte_wdata,
  input  logic                             reg_en,
  input  logic                             reg_we,
  input  logic [$clog2(REGS_PER_BANK)-1:0] reg_num,
  input  logic [DW-1:0]                    reg_wdata,
  input  logic                             bit_en,
  input  logic                             bit_we,
  input  logic [$clog2(BIT_BYTES*DW)-1:0]  bit_addr,
  input  logic                             bit_val,
  input  logic                             push,
  input  logic [DW-1:0]                    push_data,
  input  logic                             pop,
  output logic [DW-1:0]                    rd_data,
  output logic                             bit_q,
  output logic [$clog2(DEPTH)-1:0]         sp,
  output logic                             ovf,
  output logic                             unf
);
  localparam int AW    = $clog2(DEPTH);
  localparam int NB_W  = $clog2(NUM_BANKS);
  localparam int RN_W  = $clog2(REGS_PER_BANK);
  localparam int BIT_W = $clog2(BIT_BYTES * DW);
  localparam int POS_W = $clog2(DW);

  // Arbitrated one-hot request strobes
  logic push_go, pop_go, byte_go, reg_go, bit_go;
  assign push_go = push;
  assign pop_go  = pop && !push;
  assign byte_go = byte_en && !push && !pop;
  assign reg_go  = reg_en && !push && !pop && !byte_en;
  assign bit_go  = bit_en && !push && !pop && !byte_en && !reg_en;

  // Resolved addresses
  logic [AW-1:0]    reg_addr, ptr_addr, bit_byte, push_slot, acc_addr, wr_addr;
  logic [POS_W-1:0] bit_pos;
  logic [DW-1:0]    acc_data, ptr_val, wr_data;
  logic             wr_en, push_ok, pop_ok;

  bsr_resolve #(
    .AW(AW), .NB_W(NB_W), .RN_W(RN_W), .BIT_W(BIT_W), .POS_W(POS_W),
    .REGS_PER_BANK(REGS_PER_BANK), .BIT_BASE(BIT_BASE)
  ) resolve_i (
    .bank_i(bank), .reg_num_i(reg_num), .ptr_sel_i(byte_ptr), .bit_addr_i(bit_addr),
    .reg_addr_o(reg_addr), .ptr_addr_o(ptr_addr), .bit_byte_o(bit_byte), .bit_pos_o(bit_pos)
  );

  bsr_stack #(.AW(AW), .SP_INIT(SP_INIT)) stack_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_go), .pop_i(pop_go),
    .sp_o(sp), .push_slot_o(push_slot), .push_ok_o(push_ok), .pop_ok_o(pop_ok),
    .ovf_o(ovf), .unf_o(unf)
  );

  bsr_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_a_i(acc_addr), .rdata_a_o(acc_data),
    .raddr_b_i(ptr_addr), .rdata_b_o(ptr_val)
  );

  // Replace one bit of a byte
  function automatic logic [DW-1:0] put_bit(logic [DW-1:0] b, logic [POS_W-1:0] pos, logic v);
    logic [DW-1:0] r;
    r      = b;
    r[pos] = v;
    return r;
  endfunction

  always_comb begin
    acc_addr = byte_addr;
    if (pop_go)                 acc_addr = sp;
    else if (byte_go && byte_ind) acc_addr = AW'(ptr_val & DW'(DEPTH - 1));
    else if (reg_go)            acc_addr = reg_addr;
    else if (bit_go)            acc_addr = bit_byte;
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = acc_addr;
    wr_data = byte_wdata;
    if (push_go) begin
      wr_en   = push_ok;
      wr_addr = push_slot;
      wr_data = push_data;
    end else if (byte_go) begin
      wr_en = byte_we;
    end else if (reg_go) begin
      wr_en   = reg_we;
      wr_data = reg_wdata;
    end else if (bit_go) begin
      wr_en   = bit_we;
      wr_data = put_bit(acc_data, bit_pos, bit_val);
    end
  end

  logic load_rd;
  assign load_rd = (pop_go && pop_ok) || (byte_go && !byte_we) || (reg_go && !reg_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      bit_q   <= 1'b0;
    end else begin
      if (load_rd)            rd_data <= acc_data;
      if (bit_go && !bit_we)  bit_q   <= acc_data[bit_pos];
    end
  end

  assert_pop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_go && !pop_ok) |=> $stable(rd_data));
  assert_push_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_go && !push_ok) |-> !wr_en);
endmodule

// File: tb/banked_scratch_ram_tb_top.sv
module banked_scratch_ram_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] bank;
  logic byte_en, byte_we, byte_ind, byte_ptr;
  logic [6:0] byte_addr;
  logic [7:0] byte_wdata;
  logic reg_en, reg_we;
  logic [2:0] reg_num;
  logic [7:0] reg_wdata;
  logic bit_en, bit_we, bit_val;
  logic [6:0] bit_addr;
  logic push, pop;
  logic [7:0] push_data;
  logic [7:0] rd_data;
  logic bit_q, ovf, unf;
  logic [6:0] sp;

  banked_scratch_ram dut_i (
    .clk(clk), .rst_n(rst_n), .bank(bank),
    .byte_en(byte_en), .byte_we(byte_we), .byte_ind(byte_ind), .byte_ptr(byte_ptr),
    .byte_addr(byte_addr), .byte_wdata(byte_wdata),
    .reg_en(reg_en), .reg_we(reg_we), .reg_num(reg_num), .reg_wdata(reg_wdata),
    .bit_en(bit_en), .bit_we(bit_we), .bit_addr(bit_addr), .bit_val(bit_val),
    .push(push), .push_data(push_data), .pop(pop),
    .rd_data(rd_data), .bit_q(bit_q), .sp(sp), .ovf(ovf), .unf(unf)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [128];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    byte_en = 0; byte_we = 0; byte_ind = 0; byte_ptr = 0; byte_addr = 0; byte_wdata = 0;
    reg_en = 0; reg_we = 0; reg_num = 0; reg_wdata = 0;
    bit_en = 0; bit_we = 0; bit_addr = 0; bit_val = 0;
    push = 0; push_data = 0; pop = 0;
  endtask

  // Each op: drive at a falling edge, release at the next; outputs then reflect it.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic wr_byte(input int a, input int d);
    byte_en = 1; byte_we = 1; byte_addr = 7'(a); byte_wdata = 8'(d);
    step();
    model[a] = 8'(d);
  endtask

  task automatic rd_byte(input int a, input string rq);
    byte_en = 1; byte_addr = 7'(a);
    step();
    chk(rq, rd_data, model[a]);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    bank = 0;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 sp", sp, 7'h07);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 bit_q", bit_q, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 unf", unf, 0);

    // R3: direct sweep of all bytes
    for (int a = 0; a < 128; a++) wr_byte(a, (a * 37 + 5) & 8'hFF);
    for (int a = 0; a < 128; a++) rd_byte(a, "R3 direct");

    // R2: every bank and register
    for (int b = 0; b < 4; b++) begin
      bank = 2'(b);
      for (int n = 0; n < 8; n++) begin
        reg_en = 1; reg_we = 1; reg_num = 3'(n); reg_wdata = 8'(b * 40 + n * 3 + 1);
        step();
        model[8 * b + n] = 8'(b * 40 + n * 3 + 1);
      end
      for (int n = 0; n < 8; n++) begin
        reg_en = 1; reg_num = 3'(n);
        step();
        chk("R2 reg read", rd_data, model[8 * b + n]);
        rd_byte(8 * b + n, "R2 mapped byte");
      end
    end

    // R4: indirect through R0 and R1 with pointer bit 7 set
    for (int b = 0; b < 4; b++) begin
      bank = 2'(b);
      for (int k = 0; k < 12; k++) begin
        int tgt;
        tgt = 8'h30 + ((k * 13 + b * 7) % 80);
        reg_en = 1; reg_we = 1; reg_num = 0; reg_wdata = 8'(tgt | 8'h80);
        step();
        model[8 * b] = 8'(tgt | 8'h80);
        reg_en = 1; reg_we = 1; reg_num = 1; reg_wdata = 8'(tgt);
        step();
        model[8 * b + 1] = 8'(tgt);
        byte_en = 1; byte_we = 1; byte_ind = 1; byte_ptr = 0; byte_wdata = 8'(k * 19 + b);
        step();
        model[tgt] = 8'(k * 19 + b);
        rd_byte(tgt, "R4 indirect write via R0");
        byte_en = 1; byte_ind = 1; byte_ptr = 1;
        step();
        chk("R4 indirect read via R1", rd_data, model[tgt]);
      end
    end
    bank = 0;

    // R5: every bit address, set and clear
    for (int k = 0; k < 128; k++) begin
      int by, ps;
      by = 8'h20 + k / 8;
      ps = k % 8;
      bit_en = 1; bit_we = 1; bit_addr = 7'(k); bit_val = 1;
      step();
      model[by][ps] = 1'b1;
      rd_byte(by, "R5 set only one bit");
      bit_en = 1; bit_addr = 7'(k);
      step();
      chk("R5 bit read set", bit_q, 1);
      bit_en = 1; bit_we = 1; bit_addr = 7'(k); bit_val = 0;
      step();
      model[by][ps] = 1'b0;
      rd_byte(by, "R5 clear only one bit");
      bit_en = 1; bit_addr = 7'(k);
      step();
      chk("R5 bit read clear", bit_q, 0);
    end

    // R6: pushes from 07h up to 7Fh
    for (int k = 0; k < 120; k++) begin
      push = 1; push_data = 8'((k * 11 + 3) & 8'hFF);
      step();
      model[8 + k] = 8'((k * 11 + 3) & 8'hFF);
      chk("R6 sp after push", sp, 8 + k);
      rd_byte(8 + k, "R6 pushed byte");
    end

    // R8: push at the top is refused
    push = 1; push_data = 8'hA5;
    step();
    chk("R8 ovf pulse", ovf, 1);
    chk("R8 sp held", sp, 7'h7F);
    step();
    chk("R8 ovf one cycle", ovf, 0);
    rd_byte(8'h7F, "R8 top byte unchanged");

    // R7: pops from 7Fh down to 00h
    for (int s = 127; s > 0; s--) begin
      pop = 1;
      step();
      chk("R7 popped byte", rd_data, model[s]);
      chk("R7 sp after pop", sp, s - 1);
    end

    // R9: pop at the bottom is refused
    pop = 1;
    step();
    chk("R9 unf pulse", unf, 1);
    chk("R9 sp held", sp, 0);
    chk("R9 rd_data held", rd_data, model[1]);
    step();
    chk("R9 unf one cycle", unf, 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule